// File: doc/BRIEF.md
# Byte-Addressed Load/Store Unit

This block sits between the execute stage of a register-based core and a byte-addressed data memory. Each request carries a base value, a signed immediate offset, an access size, a store/load direction, an unsigned-load flag and, for stores, the register value to write. The block adds the sign-extended offset to the base, wrapping modulo 2^32, and presents the result as the memory address one clock after the request is accepted.

Stores drive one write enable per byte lane and place the data in the lanes the address selects. Byte order is little-endian: the least significant byte of a value goes to the lowest address. Loads take the word the memory returns for that address, pick out the lanes being read and extend them to 32 bits, with sign or zero fill. Half-word and word accesses must be naturally aligned. Any access that is misaligned, or that carries the reserved size code, raises a fault flag and is never split into smaller accesses. While the flag is high, no write enable is raised and the load result is zero.

Top module: `lsu_unit`

## Requirements
- R1: After reset, and until the first request, `mem_valid`, `mem_wstrb`, `mem_wdata`, `misalign` and `load_data` are all zero.
- R2: A request accepted on a rising edge appears after that edge with `mem_valid` high and `mem_addr` = base + sign-extended offset, modulo 2^32.
- R3: A byte store (size code 0) raises only write enable bit `mem_addr[1:0]` and places bits 7:0 of the store data in that lane. All other lanes of `mem_wdata` are zero.
- R4: A half-word store (size code 1) raises enables 4'b0011 when `mem_addr[1]` is 0 and 4'b1100 when it is 1. It places bits 15:0 of the store data in those lanes, and all other lanes are zero.
- R5: A word store (size code 2) raises enables 4'b1111 and writes all 32 bits of the store data unchanged.
- R6: A half-word access with `mem_addr[0]` = 1 raises `misalign`. This applies to both loads and stores.
- R7: A word access with `mem_addr[1:0]` != 0 raises `misalign`. This applies to both loads and stores.
- R8: Size code 3 is reserved and always raises `misalign`, whatever the address.
- R9: A byte load returns byte lane `mem_addr[1:0]` of `mem_rdata`, where lane k is bits 8k+7:8k. The lane is sign-extended when `req_unsigned` is 0 and zero-extended when it is 1.
- R10: A half-word load returns bits 15:0 of `mem_rdata` when `mem_addr[1]` is 0 and bits 31:16 when it is 1. The value is sign- or zero-extended in the same way as a byte load.
- R11: A word load returns `mem_rdata` unchanged. No load ever raises a write enable.
- R12: A cycle with no accepted request leaves `mem_valid`, `mem_wstrb`, `misalign` and `load_data` at zero on the next cycle.
- R13: While `misalign` is high, `mem_wstrb`, `mem_wdata` and `load_data` are zero. For stores, `load_data` is also zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request accepted on this edge |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| req_unsigned | input | 1 | Zero-extend loaded byte or half-word |
| req_base | input | AW (32) | Base register value |
| req_offset | input | OW (12) | Signed immediate offset |
| req_wdata | input | 32 | Store source register value |
| mem_valid | output | 1 | Access presented this cycle |
| mem_addr | output | AW (32) | Effective byte address |
| mem_wstrb | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Lane-placed store data |
| misalign | output | 1 | Alignment or size fault |
| mem_rdata | input | 32 | Word returned by memory for `mem_addr` |
| load_data | output | 32 | Extended load result |

## Verification
All request state sits in one register stage, so a corrupted field shows at the ports in the first cycle after the request. A wrong low address bit moves the enabled lane and the data position. A wrong size or direction bit changes the enable pattern or the fault decision. A lost unsigned flag flips the fill of the upper load bits. The stimulus uses addresses that differ only in bits 1:0, offsets that cross zero and wrap 2^32, and loaded lanes with bit 7 or bit 15 set, so that each of these errors changes a port value right away.

// File: rtl/lsu_unit.sv
module lsu_unit #(
  parameter int AW = 32,
  parameter int OW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_store,
  input  logic [1:0]    req_size,
  input  logic          req_unsigned,
  input  logic [AW-1:0] req_base,
  input  logic [OW-1:0] req_offset,
  input  logic [31:0]   req_wdata,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_wstrb,
  output logic [31:0]   mem_wdata,
  output logic          misalign,
  input  logic [31:0]   mem_rdata,
  output logic [31:0]   load_data
);

  logic          v_q, st_q, un_q, flt_q;
  logic [1:0]    sz_q;
  logic [AW-1:0] ea_q;
  logic [31:0]   sd_q;

  logic [AW-1:0] ea_n;
  logic          flt_n;

  assign ea_n = req_base + {{(AW-OW){req_offset[OW-1]}}, req_offset};

  always_comb begin
    case (req_size)
      2'd0:    flt_n = 1'b0;
      2'd1:    flt_n = ea_n[0];
      2'd2:    flt_n = |ea_n[1:0];
      default: flt_n = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      st_q  <= 1'b0;
      un_q  <= 1'b0;
      flt_q <= 1'b0;
      sz_q  <= 2'd0;
      ea_q  <= '0;
      sd_q  <= '0;
    end else begin
      v_q   <= req_valid;
      flt_q <= req_valid & flt_n;
      if (req_valid) begin
        st_q <= req_store;
        un_q <= req_unsigned;
        sz_q <= req_size;
        ea_q <= ea_n;
        sd_q <= req_wdata;
      end
    end
  end

  logic [3:0]  lane_mask;
  logic [31:0] rep;
  logic        wr_ok, rd_ok;

  always_comb begin
    case (sz_q)
      2'd0:    lane_mask = 4'b0001 << ea_q[1:0];
      2'd1:    lane_mask = ea_q[1] ? 4'b1100 : 4'b0011;
      2'd2:    lane_mask = 4'b1111;
      default: lane_mask = 4'b0000;
    endcase
  end

  assign wr_ok = v_q & st_q & ~flt_q;
  assign rd_ok = v_q & ~st_q & ~flt_q;

  assign rep = (sz_q == 2'd0) ? {4{sd_q[7:0]}} :
               (sz_q == 2'd1) ? {2{sd_q[15:0]}} : sd_q;

  assign mem_valid = v_q;
  assign mem_addr  = ea_q;
  assign misalign  = flt_q;
  assign mem_wstrb = wr_ok ? lane_mask : 4'b0000;
  assign mem_wdata = rep & {{8{mem_wstrb[3]}}, {8{mem_wstrb[2]}},
                            {8{mem_wstrb[1]}}, {8{mem_wstrb[0]}}};

  logic [31:0] lane;
  logic [31:0] ext;

  assign lane = mem_rdata >> {ea_q[1:0], 3'b000};

  always_comb begin
    case (sz_q)
      2'd0:    ext = {{24{~un_q & lane[7]}}, lane[7:0]};
      2'd1:    ext = {{16{~un_q & lane[15]}}, lane[15:0]};
      default: ext = mem_rdata;
    endcase
  end

  assign load_data = rd_ok ? ext : 32'd0;

endmodule

module lsu_unit_chk #(
  parameter int AW = 32,
  parameter int OW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] req_base,
  input logic [OW-1:0] req_offset,
  input logic          mem_valid,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_wstrb,
  input logic          misalign,
  input logic [31:0]   load_data,
  input logic [1:0]    sz,
  input logic          st
);

  logic [AW-1:0] want_ea;
  assign want_ea = req_base + {{(AW-OW){req_offset[OW-1]}}, req_offset};

  a_r2_addr: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (mem_valid && mem_addr == $past(want_ea)));

  a_r6_half_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && sz == 2'd1 && mem_addr[0]) |-> misalign);

  a_r7_word_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && sz == 2'd2 && mem_addr[1:0] != 2'b00) |-> misalign);

  a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && sz == 2'd3) |-> misalign);

  a_r13_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_wstrb == 4'b0000 && load_data == 32'd0));

  a_r11_load_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !st) |-> mem_wstrb == 4'b0000);

  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |-> (mem_wstrb == 4'b0000 && !misalign && load_data == 32'd0));

  a_r3_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mem_wstrb) != 3);

endmodule

bind lsu_unit lsu_unit_chk #(.AW(AW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .req_base(req_base), .req_offset(req_offset),
  .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_wstrb(mem_wstrb),
  .misalign(misalign), .load_data(load_data), .sz(sz_q), .st(st_q)
);

// File: tb/sim_lsu_unit.sv
`timescale 1ns/1ps
module sim_lsu_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_base = '0, req_wdata = '0, mem_rdata = '0;
  logic [11:0] req_offset = '0;
  logic        mem_valid, misalign;
  logic [31:0] mem_addr, mem_wdata, load_data;
  logic [3:0]  mem_wstrb;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lsu_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
    .req_offset(req_offset), .req_wdata(req_wdata), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata),
    .misalign(misalign), .mem_rdata(mem_rdata), .load_data(load_data)
  );

  typedef struct packed {
    logic [7:0]  rq;
    logic        st;
    logic [1:0]  sz;
    logic        un;
    logic [31:0] base;
    logic [11:0] off;
    logic [31:0] sd;
    logic [31:0] rd;
    logic [31:0] ea;
    logic [3:0]  we;
    logic [31:0] wd;
    logic        flt;
    logic [31:0] ld;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{8'd3,  1'b1, 2'd0, 1'b0, 32'h00001000, 12'h003, 32'hAABBCCDD, 32'hFFFFFFFF, 32'h00001003, 4'b1000, 32'hDD000000, 1'b0, 32'h0},        // R3 R13
    '{8'd2,  1'b1, 2'd0, 1'b0, 32'h00002001, 12'hFFF, 32'h11223344, 32'h0,        32'h00002000, 4'b0001, 32'h00000044, 1'b0, 32'h0},        // R2 R3
    '{8'd4,  1'b1, 2'd1, 1'b0, 32'h00000100, 12'h002, 32'h12345678, 32'h0,        32'h00000102, 4'b1100, 32'h56780000, 1'b0, 32'h0},        // R4
    '{8'd4,  1'b1, 2'd1, 1'b0, 32'h00000100, 12'h000, 32'h12345678, 32'h0,        32'h00000100, 4'b0011, 32'h00005678, 1'b0, 32'h0},        // R4
    '{8'd6,  1'b1, 2'd1, 1'b0, 32'h00000101, 12'h000, 32'h12345678, 32'h0,        32'h00000101, 4'b0000, 32'h00000000, 1'b1, 32'h0},        // R6
    '{8'd5,  1'b1, 2'd2, 1'b0, 32'hFFFFFFFC, 12'h004, 32'hCAFEF00D, 32'h0,        32'h00000000, 4'b1111, 32'hCAFEF00D, 1'b0, 32'h0},        // R5 R2
    '{8'd7,  1'b1, 2'd2, 1'b0, 32'h00000010, 12'h002, 32'hCAFEF00D, 32'h0,        32'h00000012, 4'b0000, 32'h00000000, 1'b1, 32'h0},        // R7
    '{8'd7,  1'b0, 2'd2, 1'b0, 32'h00000010, 12'h001, 32'h0,        32'h12345678, 32'h00000011, 4'b0000, 32'h00000000, 1'b1, 32'h0},        // R7 R13
    '{8'd9,  1'b0, 2'd0, 1'b0, 32'h00000040, 12'h001, 32'h0,        32'h11228033, 32'h00000041, 4'b0000, 32'h00000000, 1'b0, 32'hFFFFFF80}, // R9
    '{8'd9,  1'b0, 2'd0, 1'b1, 32'h00000040, 12'h001, 32'h0,        32'h11228033, 32'h00000041, 4'b0000, 32'h00000000, 1'b0, 32'h00000080}, // R9
    '{8'd9,  1'b0, 2'd0, 1'b0, 32'h00000043, 12'h000, 32'h0,        32'h7F000000, 32'h00000043, 4'b0000, 32'h00000000, 1'b0, 32'h0000007F}, // R9
    '{8'd10, 1'b0, 2'd1, 1'b0, 32'h00000042, 12'h000, 32'h0,        32'h9ABC0000, 32'h00000042, 4'b0000, 32'h00000000, 1'b0, 32'hFFFF9ABC}, // R10
    '{8'd10, 1'b0, 2'd1, 1'b1, 32'h00000040, 12'h000, 32'h0,        32'h1234F001, 32'h00000040, 4'b0000, 32'h00000000, 1'b0, 32'h0000F001}, // R10
    '{8'd11, 1'b0, 2'd2, 1'b1, 32'h00000080, 12'h7FC, 32'h0,        32'hDEADBEEF, 32'h0000087C, 4'b0000, 32'h00000000, 1'b0, 32'hDEADBEEF}, // R11
    '{8'd8,  1'b1, 2'd3, 1'b0, 32'h00000200, 12'h000, 32'h55555555, 32'h0,        32'h00000200, 4'b0000, 32'h00000000, 1'b1, 32'h0},        // R8
    '{8'd6,  1'b0, 2'd1, 1'b0, 32'h00000043, 12'h000, 32'h0,        32'hFFFFFFFF, 32'h00000043, 4'b0000, 32'h00000000, 1'b1, 32'h0}         // R6 R13
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(mem_valid == 1'b0, {tag, " mem_valid"}, 32'(mem_valid), 32'd0);
    chk(mem_wstrb == 4'b0, {tag, " mem_wstrb"}, 32'(mem_wstrb), 32'd0);
    chk(misalign == 1'b0, {tag, " misalign"}, 32'(misalign), 32'd0);
    chk(load_data == 32'd0, {tag, " load_data"}, load_data, 32'd0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 reset");
    chk(mem_wdata == 32'd0, "R1 reset mem_wdata", mem_wdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after release");

    for (int i = 0; i < NV; i++) begin
      req_valid    = 1'b1;
      req_store    = TBL[i].st;
      req_size     = TBL[i].sz;
      req_unsigned = TBL[i].un;
      req_base     = TBL[i].base;
      req_offset   = TBL[i].off;
      req_wdata    = TBL[i].sd;
      mem_rdata    = TBL[i].rd;
      @(negedge clk);
      chk(mem_valid == 1'b1, $sformatf("R2 v%0d mem_valid", i), 32'(mem_valid), 32'd1);
      chk(mem_addr == TBL[i].ea, $sformatf("R2 v%0d mem_addr", i), mem_addr, TBL[i].ea);
      chk(mem_wstrb == TBL[i].we, $sformatf("R%0d v%0d mem_wstrb", TBL[i].rq, i), 32'(mem_wstrb), 32'(TBL[i].we));
      chk(mem_wdata == TBL[i].wd, $sformatf("R%0d v%0d mem_wdata", TBL[i].rq, i), mem_wdata, TBL[i].wd);
      chk(misalign == TBL[i].flt, $sformatf("R%0d v%0d misalign", TBL[i].rq, i), 32'(misalign), 32'(TBL[i].flt));
      chk(load_data == TBL[i].ld, $sformatf("R%0d v%0d load_data", TBL[i].rq, i), load_data, TBL[i].ld);
    end

    // R12: idle cycle after a faulted access
    req_valid = 1'b0;
    mem_rdata = 32'hFFFFFFFF;
    @(negedge clk);
    chk_idle("R12 idle");

    // R12 then R5: idle request inputs are ignored, next word store works
    req_store = 1'b1; req_size = 2'd2; req_base = 32'h00000300; req_offset = 12'h000;
    req_wdata = 32'h0BADF00D;
    @(negedge clk);
    chk_idle("R12 idle inputs ignored");
    req_valid = 1'b1;
    @(negedge clk);
    chk(mem_wstrb == 4'b1111, "R5 directed mem_wstrb", 32'(mem_wstrb), 32'hF);
    chk(mem_wdata == 32'h0BADF00D, "R5 directed mem_wdata", mem_wdata, 32'h0BADF00D);
    chk(load_data == 32'd0, "R13 store load_data", load_data, 32'd0);

    // R3: byte store in each lane
    req_size = 2'd0; req_wdata = 32'h000000A5;
    for (int k = 0; k < 4; k++) begin
      req_base = 32'h00000400 + 32'(k);
      @(negedge clk);
      chk(mem_wstrb == (4'b0001 << k), $sformatf("R3 lane%0d mem_wstrb", k), 32'(mem_wstrb), 32'(4'b0001 << k));
      chk(mem_wdata == (32'hA5 << (8 * k)), $sformatf("R3 lane%0d mem_wdata", k), mem_wdata, 32'hA5 << (8 * k));
    end

    // R1: reset mid-stream clears outputs
    rst_n = 1'b0;
    #1;
    chk_idle("R1 async reset");
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after second reset");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule